// File: doc/BRIEF.md
# Daisy-Chainable Serial Shift Node

This block is the peripheral end of a four-wire synchronous serial link, and it can sit in a chain. A fast system clock oversamples the serial clock, the select and the data input. When the select falls, the node loads a parallel transmit word. While the select is low, it shifts one bit in per sampling edge and drives one bit out per shifting edge. When the select rises, it presents the received word on a parallel output.

The serial output is the top bit of a single W-bit shift register. A bit that enters on the serial input therefore leaves on the serial output exactly W bit times later. Several nodes can share one select line when each node's output feeds the next node's input, and all of them shift together.

Two parameters set the clock polarity (CPOL) and phase (CPHA), giving the four usual modes. A small state machine controls the frame:
- `ST_IDLE` moves to `ST_ACTIVE` on select-fall.
- `ST_ACTIVE` moves to `ST_DONE` on select-rise.
- `ST_DONE` lasts one cycle and raises the valid flag. It then moves to `ST_IDLE`, or straight to `ST_ACTIVE` on another select-fall.

Every serial pin passes through two synchronizing flops, so the serial clock must run at no more than a quarter of `clk`. A chain of nodes needs half serial-clock periods of at least four `clk` cycles.

Top module: `spi_chain_node`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `ser_out_en` and `par_valid` are 0 and `par_out` is all zeros.
- R2: A change on `ser_sel_n` made between clock edges takes effect on the third rising `clk` edge after it. For example, `ser_out_en` goes high in the cycle after that edge.
- R3: When the select falls, `ser_out_en` goes to 1 and `ser_out` shows bit W-1 of `par_in` before any serial-clock edge. This holds in all four modes.
- R4: Sampling happens on the rising serial-clock edge when CPOL equals CPHA and on the falling edge otherwise. Each sampled bit enters at bit 0 of the register, so the first bit received ends up as the MSB.
- R5: The edge that does not sample updates `ser_out` to the current register MSB. Transmit data therefore leaves MSB first.
- R6: An input bit appears on `ser_out` exactly W bit times after it was sampled.
- R7: When the select rises, `par_out` takes the register contents, `par_valid` is 1 for exactly one cycle, and `ser_out_en` drops.
- R8: If more than W bits are clocked, `par_out` holds the last W bits received.
- R9: While the select is high, the serial clock and input have no effect: `ser_out` and `ser_out_en` stay 0, `par_out` is unchanged, and no valid pulse occurs.
- R10: In two nodes that share a select and clock, with the first node's `ser_out` driving the second node's `ser_in`, a 2W-bit frame leaves the last W bits in the first node and the first W bits in the second.
- R11: If n < W bits are clocked, `par_out` equals the low W-n bits of the loaded word followed by the n received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the controller |
| ser_sel_n | input | 1 | Active-low select, shared along a chain |
| ser_in | input | 1 | Serial data input |
| par_in | input | FRAME_W | Word loaded for transmission when the select falls |
| ser_out | output | 1 | Serial data output (0 when not enabled) |
| ser_out_en | output | 1 | Output enable for an external tristate driver |
| par_out | output | FRAME_W | Last received frame, updated when the select rises |
| par_valid | output | 1 | One-cycle pulse when `par_out` is updated |

## Verification
Four nodes run at once, one per mode, on one data line. The data changes between trailing and leading edges, so every mode receives the same bits, and a cycle model compares all outputs on every cycle.

Each kind of frame tests a different part of the behaviour:
- Exact-width frames with transmit words of opposite MSB separate the two sampling edges and check the preload.
- Over-long and short frames show which bits survive in the register.
- Toggling the serial clock and data with the node deselected proves those pins are ignored.
- A two-node chain with a 2W-bit frame shows the full-frame delay and the MSB-first order of both transmit words at the far end.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    // frame control states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DONE   = 2'd2
    } node_state_e;

    // bit positions of the synchronized pin vector
    localparam int PIN_DATA = 0;
    localparam int PIN_CLK  = 1;
    localparam int PIN_SEL  = 2;
    localparam int PIN_N    = 3;

endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync #(
    parameter int             N       = 3,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic stage1;
            logic stage2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1 <= RST_VAL[i];
                    stage2 <= RST_VAL[i];
                end else begin
                    stage1 <= d_async[i];
                    stage2 <= stage1;
                end
            end
            assign d_sync[i] = stage2;
        end
    endgenerate

endmodule

// File: rtl/spi_chain_edge.sv
module spi_chain_edge #(
    parameter bit CPOL = 1'b0,
    parameter bit CPHA = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_s,
    input  logic sel_s,
    output logic sample_stb,
    output logic shift_stb,
    output logic sel_fall,
    output logic sel_rise
);

    localparam bit RISE_SAMPLES = (CPOL == CPHA);

    logic clk_q;
    logic sel_q;
    logic clk_up;
    logic clk_dn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= CPOL;
            sel_q <= 1'b1;
        end else begin
            clk_q <= clk_s;
            sel_q <= sel_s;
        end
    end

    assign clk_up   = clk_s & ~clk_q;
    assign clk_dn   = ~clk_s & clk_q;
    assign sel_fall = ~sel_s & sel_q;
    assign sel_rise = sel_s & ~sel_q;

    generate
        if (RISE_SAMPLES) begin : g_rise_sample
            assign sample_stb = clk_up;
            assign shift_stb  = clk_dn;
        end else begin : g_fall_sample
            assign sample_stb = clk_dn;
            assign shift_stb  = clk_up;
        end
    endgenerate

endmodule

// File: rtl/spi_chain_shreg.sv
module spi_chain_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         sample,
    input  logic         sin,
    input  logic         shift,
    output logic [W-1:0] word,
    output logic         sout
);

    logic [W-1:0] sr_q;
    logic         out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            out_q <= 1'b0;
        end else if (load) begin
            sr_q  <= load_word;
            out_q <= load_word[W-1];
        end else if (sample) begin
            sr_q  <= {sr_q[W-2:0], sin};
        end else if (shift) begin
            out_q <= sr_q[W-1];
        end
    end

    assign word = sr_q;
    assign sout = out_q;

    // R4
    sample_enters_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !load) |=> (word[0] == $past(sin)));

endmodule

// File: rtl/spi_chain_node.sv
module spi_chain_node
    import spi_chain_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter bit CPOL    = 1'b0,
    parameter bit CPHA    = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_sel_n,
    input  logic               ser_in,
    input  logic [FRAME_W-1:0] par_in,
    output logic               ser_out,
    output logic               ser_out_en,
    output logic [FRAME_W-1:0] par_out,
    output logic               par_valid
);

    localparam logic [PIN_N-1:0] PIN_IDLE = {1'b1, CPOL, 1'b0};

    node_state_e        state_q;
    node_state_e        state_d;
    logic [PIN_N-1:0]   pins_raw;
    logic [PIN_N-1:0]   pins_s;
    logic               sample_stb;
    logic               shift_stb;
    logic               sel_fall;
    logic               sel_rise;
    logic               do_load;
    logic               do_sample;
    logic               do_shift;
    logic [FRAME_W-1:0] word;
    logic               sout;

    assign pins_raw[PIN_DATA] = ser_in;
    assign pins_raw[PIN_CLK]  = ser_clk;
    assign pins_raw[PIN_SEL]  = ser_sel_n;

    spi_chain_sync #(
        .N       (PIN_N),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_raw),
        .d_sync  (pins_s)
    );

    spi_chain_edge #(
        .CPOL (CPOL),
        .CPHA (CPHA)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_s      (pins_s[PIN_CLK]),
        .sel_s      (pins_s[PIN_SEL]),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb),
        .sel_fall   (sel_fall),
        .sel_rise   (sel_rise)
    );

    assign do_load   = (state_q != ST_ACTIVE) && sel_fall;
    assign do_sample = (state_q == ST_ACTIVE) && sample_stb && !sel_rise;
    assign do_shift  = (state_q == ST_ACTIVE) && shift_stb && !sel_rise;

    spi_chain_shreg #(
        .W (FRAME_W)
    ) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_word (par_in),
        .sample    (do_sample),
        .sin       (pins_s[PIN_DATA]),
        .shift     (do_shift),
        .word      (word),
        .sout      (sout)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sel_fall) state_d = ST_ACTIVE;
            ST_ACTIVE: if (sel_rise) state_d = ST_DONE;
            ST_DONE:   state_d = sel_fall ? ST_ACTIVE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ser_out_en = (state_q == ST_ACTIVE);
        par_valid  = (state_q == ST_DONE);
        ser_out    = ser_out_en & sout;
    end

    // received-frame latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_out <= '0;
        end else if ((state_q == ST_ACTIVE) && sel_rise) begin
            par_out <= word;
        end
    end

    // R3
    preload_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_out_en) |-> (ser_out == par_in[FRAME_W-1]));

    // R7
    valid_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_out_en) |-> par_valid);

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |=> !par_valid);

    // R9
    idle_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(par_out));

endmodule

// File: tb/test_spi_chain_node.sv
`timescale 1ns/1ps
module test_spi_chain_node;

    localparam int W    = 8;
    localparam int HALF = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n    = 1'b0;
    logic         base_clk = 1'b0;
    logic         sel_n    = 1'b1;
    logic         din      = 1'b0;
    logic [W-1:0] tx_word  = 8'h3C;
    logic [W-1:0] tx_next  = 8'h96;

    logic         so [4];
    logic         oe [4];
    logic [W-1:0] pw [4];
    logic         pv [4];

    generate
        for (genvar m = 0; m < 4; m++) begin : g_mode
            localparam bit MP = (m >= 2);
            localparam bit MH = ((m % 2) == 1);
            logic node_clk;
            assign node_clk = base_clk ^ MP;
            spi_chain_node #(.FRAME_W(W), .CPOL(MP), .CPHA(MH)) i_spi_chain_node (
                .clk(clk), .rst_n(rst_n), .ser_clk(node_clk), .ser_sel_n(sel_n),
                .ser_in(din), .par_in(tx_word), .ser_out(so[m]), .ser_out_en(oe[m]),
                .par_out(pw[m]), .par_valid(pv[m]));
        end
    endgenerate

    logic         nx_so, nx_oe, nx_pv;
    logic [W-1:0] nx_pw;
    spi_chain_node #(.FRAME_W(W), .CPOL(1'b0), .CPHA(1'b0)) i_spi_chain_node_next (
        .clk(clk), .rst_n(rst_n), .ser_clk(base_clk), .ser_sel_n(sel_n),
        .ser_in(so[0]), .par_in(tx_next), .ser_out(nx_so), .ser_out_en(nx_oe),
        .par_out(nx_pw), .par_valid(nx_pv));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    // ---------------- reference model ----------------
    typedef struct packed {logic ck; logic sel; logic d;} pins_t;
    pins_t        hist[$];
    bit           m_act  [4];
    logic [W-1:0] m_sr   [4];
    logic         m_out  [4];
    logic [W-1:0] m_word [4];
    bit           m_val  [4];

    always @(posedge clk) begin
        pins_t cur;
        pins_t prv;
        logic  ck_c, ck_p, up, dn, smp, shf;
        bit    on_rise;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 4; i++) hist.push_back('{ck:1'b0, sel:1'b1, d:1'b0});
            for (int m = 0; m < 4; m++) begin
                m_act[m] = 1'b0; m_sr[m] = '0; m_out[m] = 1'b0;
                m_word[m] = '0;  m_val[m] = 1'b0;
            end
        end else begin
            hist.push_back('{ck:base_clk, sel:sel_n, d:din});
            cur = hist[hist.size()-3];
            prv = hist[hist.size()-4];
            if (hist.size() > 8) void'(hist.pop_front());
            for (int m = 0; m < 4; m++) begin
                ck_c    = cur.ck ^ (m >= 2);
                ck_p    = prv.ck ^ (m >= 2);
                up      = !ck_p && ck_c;
                dn      = ck_p && !ck_c;
                on_rise = (m == 0) || (m == 3);
                smp     = on_rise ? up : dn;
                shf     = on_rise ? dn : up;
                m_val[m] = 1'b0;
                if (m_act[m]) begin
                    if (!prv.sel && cur.sel) begin
                        m_act[m] = 1'b0; m_word[m] = m_sr[m]; m_val[m] = 1'b1;
                    end else if (smp) begin
                        m_sr[m] = {m_sr[m][W-2:0], cur.d};
                    end else if (shf) begin
                        m_out[m] = m_sr[m][W-1];
                    end
                end else if (prv.sel && !cur.sel) begin
                    m_act[m] = 1'b1; m_sr[m] = tx_word; m_out[m] = tx_word[W-1];
                end
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!done) begin
            for (int m = 0; m < 4; m++) begin
                chk(so[m] === (m_out[m] & m_act[m]), rst_n ? "R5" : "R1", "ser_out vs model",
                    32'(so[m]), 32'(m_out[m] & m_act[m]));
                chk(oe[m] === m_act[m], rst_n ? "R3" : "R1", "ser_out_en vs model",
                    32'(oe[m]), 32'(m_act[m]));
                chk(pw[m] === m_word[m], rst_n ? "R7" : "R1", "par_out vs model",
                    32'(pw[m]), 32'(m_word[m]));
                chk(pv[m] === m_val[m], rst_n ? "R7" : "R1", "par_valid vs model",
                    32'(pv[m]), 32'(m_val[m]));
            end
        end
    end

    int vcount [4];
    always @(posedge clk) begin
        for (int m = 0; m < 4; m++) if (pv[m] === 1'b1) vcount[m]++;
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic got);
        din = b;
        cyc(2);
        got = nx_so;
        base_clk = 1'b1;
        cyc(HALF);
        base_clk = 1'b0;
        cyc(2);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, output logic [31:0] got);
        logic g;
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(v[i], g);
            got = {got[30:0], g};
        end
    endtask

    task automatic select();
        sel_n = 1'b0;
        cyc(6);
    endtask

    task automatic deselect();
        cyc(2);
        sel_n = 1'b1;
        cyc(6);
    endtask

    task automatic clear_vcount();
        for (int m = 0; m < 4; m++) vcount[m] = 0;
    endtask

    initial begin
        logic [31:0] got;
        logic [W-1:0] held [4];
        cyc(3);
        for (int m = 0; m < 4; m++) begin
            // R1
            chk(so[m] == 1'b0 && oe[m] == 1'b0 && pv[m] == 1'b0, "R1", "outputs in reset",
                {so[m], oe[m], pv[m]}, 0);
            chk(pw[m] == '0, "R1", "par_out in reset", pw[m], 0);
        end
        rst_n = 1'b1;
        cyc(4);

        // R2: select takes effect on third edge
        sel_n = 1'b0;
        cyc(1); chk(oe[0] == 1'b0, "R2", "enable after 1 edge", oe[0], 0);
        cyc(1); chk(oe[0] == 1'b0, "R2", "enable after 2 edges", oe[0], 0);
        cyc(1); chk(oe[0] == 1'b1, "R2", "enable after 3 edges", oe[0], 1);
        cyc(3);
        for (int m = 0; m < 4; m++) begin
            // R3: MSB of 0x3C is 0
            chk(oe[m] == 1'b1 && so[m] == tx_word[W-1], "R3", "preload MSB 0",
                {oe[m], so[m]}, {1'b1, tx_word[W-1]});
        end
        clear_vcount();
        send_bits(32'hA5, W, got);
        deselect();
        for (int m = 0; m < 4; m++) begin
            chk(pw[m] == 8'hA5, "R4", "received word A5", pw[m], 8'hA5);
            chk(vcount[m] == 1, "R7", "one valid pulse", vcount[m], 1);
            chk(oe[m] == 1'b0, "R7", "enable dropped", oe[m], 0);
        end

        // second frame, preload MSB 1
        tx_word = 8'hC3;
        select();
        for (int m = 0; m < 4; m++)
            chk(so[m] == 1'b1, "R3", "preload MSB 1", so[m], 1);
        send_bits(32'h5A, W, got);
        deselect();
        for (int m = 0; m < 4; m++)
            chk(pw[m] == 8'h5A, "R4", "received word 5A", pw[m], 8'h5A);

        // R8: over-long frame, 11 bits 101_1100_0110
        tx_word = 8'h0F;
        select();
        send_bits(32'h5C6, 11, got);
        deselect();
        for (int m = 0; m < 4; m++)
            chk(pw[m] == 8'hC6, "R8", "last W bits kept", pw[m], 8'hC6);

        // R11: short frame, 3 bits 101 after preload 0x3C -> 0xE5
        tx_word = 8'h3C;
        select();
        send_bits(32'h5, 3, got);
        deselect();
        for (int m = 0; m < 4; m++)
            chk(pw[m] == 8'hE5, "R11", "short frame mix", pw[m], 8'hE5);

        // R9: deselected activity is ignored
        for (int m = 0; m < 4; m++) held[m] = pw[m];
        clear_vcount();
        for (int i = 0; i < 6; i++) begin
            din = ~din; cyc(2);
            base_clk = 1'b1; cyc(HALF);
            base_clk = 1'b0; cyc(2);
            for (int m = 0; m < 4; m++)
                chk(so[m] == 1'b0 && oe[m] == 1'b0, "R9", "idle output quiet",
                    {so[m], oe[m]}, 0);
        end
        cyc(4);
        for (int m = 0; m < 4; m++) begin
            chk(pw[m] == held[m], "R9", "par_out unchanged", pw[m], held[m]);
            chk(vcount[m] == 0, "R9", "no valid pulse", vcount[m], 0);
        end

        // R10 / R6 / R5: two-node chain, 2W bits 0x5A then 0x81
        tx_word = 8'hC3;
        tx_next = 8'h96;
        select();
        send_bits(32'h5A81, 2 * W, got);
        deselect();
        chk(pw[0] == 8'h81, "R10", "first node keeps last frame", pw[0], 8'h81);
        chk(nx_pw == 8'h5A, "R6", "second node got first frame", nx_pw, 8'h5A);
        chk(got[15:8] == 8'h96, "R5", "far node word first, MSB first", got[15:8], 8'h96);
        chk(got[7:0] == 8'hC3, "R6", "near node word one frame later", got[7:0], 8'hC3);

        cyc(4);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule